// File: doc/BRIEF.md
# Threshold-Driven Flow-Control Frame Sender

This block watches the fill level of a receive buffer and tells the link partner to stop sending when the buffer is close to full. When the level reaches a programmable upper threshold, the block sends an 802.3x MAC Control PAUSE frame. The frame's time field carries a programmable number of pause quanta. The frame leaves as a 60-byte stream of bytes toward the MAC transmit path, with valid, start and end markers and a ready handshake. The MAC appends the FCS after the end marker.

While the level stays at or above the upper threshold, the block sends the same frame again on a programmable refresh interval, so the partner never resumes early. When the level falls below a lower release threshold, the block sends a frame with zero time, which lets the partner resume at once. The gap between the two thresholds gives hysteresis. Frame generation depends on a transmit-pause enable, so a port set for asymmetric operation, where this side only obeys pauses, never sends any frame.

Top module: `pause_tx_gen`

## Requirements
- R1: While reset is held and straight after it is released, `tx_valid` is low and no frame is sent.
- R2: With `tx_pause_en` high and no pause advertised, a clock edge that samples `fill_level >= pause_thresh` with the sender idle starts a frame. Its first byte, with `tx_sop` high, shows on the output right after that edge.
- R3: Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are `src_mac` with the most significant byte first. Bytes 12-13 are 88 08 and bytes 14-15 are 00 01. Bytes 16-17 are the pause time, most significant byte first. For a pause frame the time equals `pause_quanta`, captured when the frame starts.
- R4: Bytes 18 to 59 are zero. `tx_eop` is high on byte 59 only and `tx_sop` on byte 0 only, so every frame is exactly 60 bytes long.
- R5: A byte is taken only on an edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the data and both markers hold steady.
- R6: Once a pause has been advertised, an idle edge that samples `fill_level < release_thresh` starts a frame with time 0000. A level between the two thresholds starts no frame, and no further frame follows the release while the level stays below `pause_thresh`.
- R7: While a pause is advertised and the level stays at or above `pause_thresh`, a refresh frame with the same layout starts `refresh_cycles`+1 cycles after the previous frame started, and never earlier. This holds for `refresh_cycles` of 60 or more with `tx_ready` held high.
- R8: While `tx_pause_en` is low, no frame starts, whatever the fill level.
- R9: A frame is never cut short. A request that arises during a frame starts its own frame with `tx_sop` exactly two cycles after the cycle in which the previous `tx_eop` byte was shown and taken, which leaves one idle cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_pause_en | input | 1 | Enables sending of flow-control frames |
| fill_level | input | LVL_W | Current receive-buffer occupancy |
| pause_thresh | input | LVL_W | Level at or above which a pause is requested |
| release_thresh | input | LVL_W | Level below which an advertised pause is cancelled |
| pause_quanta | input | 16 | Pause time placed in pause and refresh frames |
| refresh_cycles | input | TMR_W | Cycles from one frame start to the refresh decision |
| src_mac | input | 48 | Source address placed in bytes 6-11 |
| tx_ready | input | 1 | MAC accepts the current byte |
| tx_valid | output | 1 | A frame byte is presented |
| tx_data | output | 8 | Frame byte |
| tx_sop | output | 1 | First byte of a frame |
| tx_eop | output | 1 | Last byte of the 60-byte body |

## Verification
A start decision takes one register stage. So the bench changes `fill_level` or `tx_pause_en` just after an edge and expects `tx_sop` exactly one cycle later. The refresh frame is expected `refresh_cycles`+1 cycles after the previous start. A frame queued behind another is expected two cycles after the previous end-marker cycle. A monitor samples on the falling edge and records the cycle of each start and end, and each timing check compares those recorded numbers with the values computed from the requirements. Byte contents are checked only on cycles where valid and ready are both high, and that holds under both steady and random `tx_ready`.

// File: rtl/pftx_pkg.sv
package pftx_pkg;

  localparam int FRAME_BYTES = 60;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  localparam logic [47:0] CTRL_GROUP_ADDR = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_ETHERTYPE  = 16'h8808;
  localparam logic [15:0] CTRL_OPCODE     = 16'h0001;

  typedef enum logic [1:0] {
    REQ_NONE    = 2'd0,
    REQ_PAUSE   = 2'd1,
    REQ_RELEASE = 2'd2
  } req_e;

  // Byte at position idx of the 60-byte control frame body.
  function automatic logic [7:0] body_byte(input logic [IDX_W-1:0] idx,
                                           input logic [47:0]      sa,
                                           input logic [15:0]      qt);
    int i;
    logic [7:0] b;
    i = int'(idx);
    b = 8'h00;
    if (i < 6)       b = CTRL_GROUP_ADDR[8*(5-i) +: 8];
    else if (i < 12) b = sa[8*(11-i) +: 8];
    else if (i < 14) b = CTRL_ETHERTYPE[8*(13-i) +: 8];
    else if (i < 16) b = CTRL_OPCODE[8*(15-i) +: 8];
    else if (i < 18) b = qt[8*(17-i) +: 8];
    return b;
  endfunction

endpackage

// File: rtl/pftx_level_ctl.sv
module pftx_level_ctl
  import pftx_pkg::*;
#(
  parameter int LVL_W = 12,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] upper_thr,
  input  logic [LVL_W-1:0] lower_thr,
  input  logic [TMR_W-1:0] refresh_len,
  input  logic             gen_busy,
  output logic             start,
  output logic             zero_time
);

  logic             advertised_q, advertised_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  req_e             req;
  logic             above, below, expired;

  assign above   = (level >= upper_thr);
  assign below   = (level <  lower_thr);
  assign expired = (tmr_q == '0);

  always_comb begin
    req = REQ_NONE;
    if (enable && !gen_busy) begin
      if (advertised_q && below)                  req = REQ_RELEASE;
      else if (above && (!advertised_q || expired)) req = REQ_PAUSE;
    end
  end

  always_comb begin
    advertised_d = advertised_q;
    if (req == REQ_PAUSE)        advertised_d = 1'b1;
    else if (req == REQ_RELEASE) advertised_d = 1'b0;
  end

  always_comb begin
    tmr_en = 1'b0;
    tmr_d  = tmr_q;
    if (req == REQ_PAUSE) begin
      tmr_en = 1'b1;
      tmr_d  = refresh_len;
    end else if (!expired) begin
      tmr_en = 1'b1;
      tmr_d  = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      advertised_q <= 1'b0;
      tmr_q        <= '0;
    end else begin
      advertised_q <= advertised_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign start     = (req != REQ_NONE);
  assign zero_time = (req == REQ_RELEASE);

endmodule

// File: rtl/pftx_frame_gen.sv
module pftx_frame_gen
  import pftx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        zero_time,
  input  logic [15:0] quanta,
  input  logic [47:0] src_addr,
  input  logic        ready,
  output logic        busy,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_first,
  output logic        out_last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [15:0]      time_q;
  logic [47:0]      sa_q;
  logic             load_en, adv_en;

  assign load_en = !busy_q && start;
  assign adv_en  = busy_q && ready;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (load_en) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (adv_en) begin
      if (idx_q == LAST_IDX) busy_d = 1'b0;
      else                   idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      time_q <= '0;
      sa_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      if (load_en) begin
        time_q <= zero_time ? 16'h0000 : quanta;
        sa_q   <= src_addr;
      end
    end
  end

  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_first = busy_q && (idx_q == '0);
  assign out_last  = busy_q && (idx_q == LAST_IDX);
  assign out_data  = busy_q ? body_byte(idx_q, sa_q, time_q) : 8'h00;

endmodule

// File: rtl/pause_tx_gen.sv
module pause_tx_gen #(
  parameter int LVL_W = 12,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_pause_en,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] pause_thresh,
  input  logic [LVL_W-1:0] release_thresh,
  input  logic [15:0]      pause_quanta,
  input  logic [TMR_W-1:0] refresh_cycles,
  input  logic [47:0]      src_mac,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_sop,
  output logic             tx_eop
);

  logic gen_busy, start, zero_time;

  pftx_level_ctl #(.LVL_W(LVL_W), .TMR_W(TMR_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (tx_pause_en),
    .level       (fill_level),
    .upper_thr   (pause_thresh),
    .lower_thr   (release_thresh),
    .refresh_len (refresh_cycles),
    .gen_busy    (gen_busy),
    .start       (start),
    .zero_time   (zero_time)
  );

  pftx_frame_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .zero_time (zero_time),
    .quanta    (pause_quanta),
    .src_addr  (src_mac),
    .ready     (tx_ready),
    .busy      (gen_busy),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_first (tx_sop),
    .out_last  (tx_eop)
  );

endmodule

// File: rtl/pause_tx_gen_chk.sv
module pause_tx_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_pause_en,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_sop,
  input logic       tx_eop
);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  // R4
  markers_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sop && tx_eop));

  // R3
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> (tx_data == 8'h01));

  // R9
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eop) |=> !tx_valid);

  // R8
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !tx_pause_en) |=> !tx_valid);

  // R9
  no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_eop) |=> tx_valid);

endmodule

bind pause_tx_gen pause_tx_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_pause_en (tx_pause_en),
  .tx_ready    (tx_ready),
  .tx_valid    (tx_valid),
  .tx_data     (tx_data),
  .tx_sop      (tx_sop),
  .tx_eop      (tx_eop)
);

// File: tb/pause_tx_gen_bench.sv
module pause_tx_gen_bench;

  localparam int LVL_W = 12;
  localparam int TMR_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tx_pause_en = 1'b0;
  logic [LVL_W-1:0] fill_level = '0;
  logic [LVL_W-1:0] pause_thresh = 12'd100;
  logic [LVL_W-1:0] release_thresh = 12'd40;
  logic [15:0]      pause_quanta = 16'h1234;
  logic [TMR_W-1:0] refresh_cycles = 16'd200;
  logic [47:0]      src_mac = 48'h0A1B_2C3D_4E5F;
  logic             tx_ready = 1'b1;
  logic             tx_valid, tx_sop, tx_eop;
  logic [7:0]       tx_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit rnd_ready = 1'b0;

  int frames = 0;
  int bi = 0;
  int last_sop = 0, prev_sop = 0, last_eop = 0;
  bit seen_sop = 1'b0;
  logic [15:0] cur_time = '0, last_time = '0;

  pause_tx_gen #(.LVL_W(LVL_W), .TMR_W(TMR_W)) u_pause_tx_gen (
    .clk(clk), .rst_n(rst_n), .tx_pause_en(tx_pause_en), .fill_level(fill_level),
    .pause_thresh(pause_thresh), .release_thresh(release_thresh),
    .pause_quanta(pause_quanta), .refresh_cycles(refresh_cycles), .src_mac(src_mac),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] want_byte(input int i, input logic [47:0] sa);
    logic [7:0] hdr [0:15];
    hdr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01,
            sa[47:40], sa[39:32], sa[31:24], sa[23:16], sa[15:8], sa[7:0],
            8'h88, 8'h08, 8'h00, 8'h01};
    if (i < 16) return hdr[i];
    return 8'h00;
  endfunction

  // Ready driver
  initial forever begin
    @(posedge clk); #1;
    tx_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // Monitor: byte taken when valid and ready at the following edge
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (tx_sop && !seen_sop) begin
        seen_sop = 1'b1;
        prev_sop = last_sop;
        last_sop = cyc;
      end
      if (tx_ready) begin
        // R4
        chk(tx_sop == (bi == 0), "R4", "sop position", tx_sop, bi == 0);
        chk(tx_eop == (bi == 59), "R4", "eop position", tx_eop, bi == 59);
        if (bi == 16)      cur_time[15:8] = tx_data;
        else if (bi == 17) cur_time[7:0]  = tx_data;
        else if (bi < 16)
          chk(tx_data == want_byte(bi, src_mac), "R3", "header byte", tx_data, want_byte(bi, src_mac));
        else
          chk(tx_data == 8'h00, "R4", "pad byte", tx_data, 0);
        if (tx_eop || bi >= 59) begin
          frames++;
          last_time = cur_time;
          last_eop = cyc;
          seen_sop = 1'b0;
          bi = 0;
        end else begin
          bi++;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_frames(input int n);
    while (frames < n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", frames, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int k, f;
    void'($urandom(32'h5EED));
    step(3);
    // R1
    chk(tx_valid == 1'b0, "R1", "valid in reset", tx_valid, 0);
    rst_n = 1'b1;
    step(5);
    chk(tx_valid == 1'b0 && frames == 0, "R1", "idle after reset", tx_valid, 0);

    tx_pause_en = 1'b1;
    fill_level = 12'd10;
    step(20);
    chk(frames == 0 && !tx_valid, "R6", "no frame at low level", frames, 0);

    // R2: threshold reached
    fill_level = 12'd100;
    k = cyc;
    wait_frames(1);
    chk(last_sop == k + 1, "R2", "start cycle", last_sop, k + 1);
    chk(last_time == 16'h1234, "R3", "pause time", last_time, 16'h1234);

    // R7: refresh after refresh_cycles+1
    wait_frames(2);
    chk(last_sop - prev_sop == 201, "R7", "refresh spacing", last_sop - prev_sop, 201);
    chk(last_time == 16'h1234, "R7", "refresh time", last_time, 16'h1234);

    // R6: between thresholds, no frame
    fill_level = 12'd70;
    step(300);
    chk(frames == 2, "R6", "hysteresis band silent", frames, 2);

    // R6: release
    fill_level = 12'd20;
    k = cyc;
    wait_frames(3);
    chk(last_sop == k + 1, "R6", "release start", last_sop, k + 1);
    chk(last_time == 16'h0000, "R6", "release time", last_time, 0);
    step(300);
    chk(frames == 3, "R6", "single release", frames, 3);

    // R8: disabled
    tx_pause_en = 1'b0;
    fill_level = 12'd300;
    step(300);
    chk(frames == 3 && !tx_valid, "R8", "no frame when disabled", frames, 3);

    // R9: queued release behind a pause frame, random ready
    rnd_ready = 1'b1;
    pause_quanta = 16'hBEEF;
    tx_pause_en = 1'b1;
    k = cyc;
    step(20);
    chk(last_sop == k + 1, "R8", "start after enable", last_sop, k + 1);
    fill_level = 12'd5;
    wait_frames(4);
    chk(last_time == 16'hBEEF, "R9", "frame not cut", last_time, 16'hBEEF);
    f = last_eop;
    wait_frames(5);
    chk(last_sop == f + 2, "R9", "queued start", last_sop, f + 2);
    chk(last_time == 16'h0000, "R9", "queued release time", last_time, 0);

    // Random pause/release pairs with random ready
    refresh_cycles = 16'd3000;
    for (int it = 0; it < 8; it++) begin
      logic [15:0] q;
      q = 16'($urandom);
      pause_quanta = q;
      src_mac = {16'($urandom), 32'($urandom)};
      fill_level = 12'(100 + ($urandom % 900));
      wait_frames(6 + 2 * it);
      chk(last_time == q, "R3", "random pause time", last_time, q);
      fill_level = 12'($urandom % 40);
      wait_frames(7 + 2 * it);
      chk(last_time == 16'h0000, "R6", "random release time", last_time, 0);
    end
    step(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule